// File: doc/BRIEF.md
# Sticky-Enable Watchdog Timer

This block is a hardware watchdog placed behind a plain 32-bit register bus. Software arms it by setting an enable bit in a control register, together with a timeout in whole seconds. It must then keep writing that register, with any value, before the timeout runs out. If it stops, the block drives a fixed-length reset pulse to the rest of the system and sets a reset-cause flag.

Once armed, the watchdog cannot be disarmed by software. Only a system reset clears the enable bit. The timeout field can be changed at any time, and the new value applies from the write that carries it. The reset-cause flag lives in a separate status register. It survives the system reset that the watchdog itself causes, so software can learn after the restart why the restart happened. It is cleared only by power-on reset or by writing 1 to it. A read-only version register completes the map.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the control register (byte address 0x14) and the status register (byte address 0x18) read as zero, and the reset output is low.
- R2: Control bit 7 is the enable. Once it has been written as 1, later control writes with bit 7 at 0 leave it set. Only the power-on or system reset input clears it.
- R3: A read of the control register returns the enable in bit 7 and the timeout in bits 11:8. All other bits read as zero, whatever was written to them.
- R4: Every write to the control register restarts the countdown from the full timeout, whatever the data written.
- R5: While enabled, the reset output rises on the clock edge that ends exactly T x CLK_HZ cycles after the edge that sampled the last control write, where T is the timeout field.
- R6: A timeout field of 0 behaves as a timeout of 1 second.
- R7: A control write that changes the timeout makes the new value govern the countdown that starts at that write.
- R8: On expiry the reset output stays high for exactly RST_CYCLES cycles. The counter then halts, and no further pulse occurs until a reset input is applied.
- R9: Status bit 31 is set on expiry and is kept through the system reset input. It is cleared by the power-on reset or by a status write with bit 31 at 1. A status write with bit 31 at 0 leaves it unchanged. The other status bits read as zero.
- R10: The version register at byte address 0x1C reads VERSION in bits 15:0 and zero in bits 31:16. Writes to it have no effect.
- R11: While the enable is 0 the block never expires, whatever the timeout field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears all state except the reset-cause flag |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational, zero when rd_en is low |
| wdt_rst | output | 1 | Watchdog reset pulse to the system |

## Verification
The bench builds the block with CLK_HZ set to 10 and keeps RST_CYCLES at 16, so one watchdog second lasts ten clocks. With these values, every timeout from 0 through 3 seconds can be measured cycle-exactly within a few dozen clocks, including the edge just before and the edge of expiry. The whole 16-cycle pulse and the quiet period after it also fit in a short run. VERSION is set to 16'hA5C3, a pattern with ones and zeros spread across both bytes, so a dropped or shifted half shows up in the version read.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          RST_CYCLES = 16,
  parameter logic [15:0] VERSION    = 16'h0001
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        wdt_rst
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [7:0] A_CTRL = 8'h14;
  localparam logic [7:0] A_STAT = 8'h18;
  localparam logic [7:0] A_VER  = 8'h1C;

  logic          en;
  logic [3:0]    tmo;
  logic [PW-1:0] presc;
  logic [3:0]    secs;
  logic          fired;
  logic [RW-1:0] pulse;
  logic          cause;

  wire ctrl_wr = wr_en && (addr == A_CTRL);
  wire stat_wr = wr_en && (addr == A_STAT);
  wire [3:0] load_tmo = ctrl_wr ? wr_data[11:8] : tmo;
  wire [3:0] load_sec = (load_tmo == 4'd0) ? 4'd1 : load_tmo;
  wire tick   = (presc == PW'(CLK_HZ - 1));
  wire expire = en && !fired && !ctrl_wr && tick && (secs == 4'd1);

  assign wdt_rst = (pulse != '0);

  always_ff @(posedge clk) begin
    if (!por_n || !sys_rst_n) begin
      en    <= 1'b0;
      tmo   <= 4'd0;
      presc <= '0;
      secs  <= 4'd1;
      fired <= 1'b0;
      pulse <= '0;
    end else begin
      if (pulse != '0) pulse <= pulse - 1'b1;
      if (ctrl_wr) begin
        en  <= en | wr_data[7];
        tmo <= wr_data[11:8];
      end
      if (ctrl_wr || !en) begin
        presc <= '0;
        secs  <= load_sec;
      end else if (!fired) begin
        if (tick) begin
          presc <= '0;
          if (expire) begin
            fired <= 1'b1;
            pulse <= RW'(RST_CYCLES);
          end else begin
            secs <= secs - 4'd1;
          end
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)                        cause <= 1'b0;
    else if (expire)                   cause <= 1'b1;
    else if (stat_wr && wr_data[31])   cause <= 1'b0;
  end

  always_comb begin
    rd_data = 32'd0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rd_data = {20'd0, tmo, en, 7'd0};
        A_STAT:  rd_data = {cause, 31'd0};
        A_VER:   rd_data = {16'd0, VERSION};
        default: rd_data = 32'd0;
      endcase
    end
  end

  // R2
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $past(en) |-> en);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    !en |-> !wdt_rst);
  // R4
  kick_holds_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (ctrl_wr && !fired && !wdt_rst) |=> !wdt_rst);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (fired && !wdt_rst) |=> !wdt_rst);
  // R9
  cause_on_fire_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $rose(wdt_rst) |-> cause);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int HZ  = 10;
  localparam int RC  = 16;
  localparam logic [15:0] VER = 16'hA5C3;

  logic clk = 1'b0;
  logic por_n, sys_rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wr_data, rd_data;
  logic wdt_rst;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_timer #(.CLK_HZ(HZ), .RST_CYCLES(RC), .VERSION(VER)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .wdt_rst(wdt_rst));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    check(tag, seen, 0);
  endtask

  task automatic do_por();
    por_n = 1'b0; wait_cyc(2); por_n = 1'b1;
  endtask

  task automatic do_sys();
    sys_rst_n = 1'b0; wait_cyc(2); sys_rst_n = 1'b1;
  endtask

  // write ctrl, then verify rise exactly at n cycles and the pulse length
  task automatic expiry(input logic [31:0] d, input int n, input string tag);
    int hi = 0;
    wr(8'h14, d);
    wait_cyc(n - 1);
    check({tag, " low before expiry"}, wdt_rst, 0);
    wait_cyc(1);
    check({tag, " rise at expiry"}, wdt_rst, 1);
    for (int i = 1; i < RC; i++) begin
      @(negedge clk);
      if (wdt_rst) hi++;
    end
    check("R8 pulse stays high", hi, RC - 1);
    wait_cyc(1);
    check("R8 pulse ends", wdt_rst, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h14, v); check("R1 ctrl after reset", v, 0);
    rd(8'h18, v); check("R1 status after reset", v, 0);
    check("R1 wdt_rst after reset", wdt_rst, 0);
    rd(8'h1C, v); check("R10 version", v, {16'd0, VER});
  endtask

  task automatic t_format_idle();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FF7F);
    rd(8'h14, v); check("R3 ctrl readback mask", v, 32'h0000_0F00);
    quiet(200, "R11 disabled never expires");
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, v); check("R10 version write ignored", v, {16'd0, VER});
    wr(8'h18, 32'h7FFF_FFFF);
    rd(8'h18, v); check("R9 status other bits zero", v, 0);
  endtask

  task automatic t_sticky_kick();
    logic [31:0] v;
    wr(8'h14, 32'h0000_0380);
    for (int k = 0; k < 4; k++) begin
      wait_cyc(25);
      wr(8'h14, 32'h0000_0300);
    end
    rd(8'h14, v); check("R2 enable sticky after 0 write", v, 32'h0000_0380);
    quiet(25, "R4 kicks keep reset away");
  endtask

  task automatic t_retime_fire();
    logic [31:0] v;
    expiry(32'h0000_0100, HZ, "R7 timeout cut to 1s");
    quiet(100, "R8 no second pulse");
    rd(8'h18, v); check("R9 cause set", v, 32'h8000_0000);
    wr(8'h18, 32'h0);
    rd(8'h18, v); check("R9 write 0 keeps cause", v, 32'h8000_0000);
    do_sys();
    rd(8'h14, v); check("R2 sys reset clears ctrl", v, 0);
    rd(8'h18, v); check("R9 cause survives sys reset", v, 32'h8000_0000);
    wr(8'h18, 32'h8000_0000);
    rd(8'h18, v); check("R9 write 1 clears cause", v, 0);
  endtask

  task automatic t_zero_and_two();
    logic [31:0] v;
    expiry(32'h0000_0080, HZ, "R6 zero timeout as 1s");
    do_sys();
    expiry(32'h0000_0280, 2 * HZ, "R5 two second expiry");
    do_sys();
    expiry(32'h0000_0380, 3 * HZ, "R5 three second expiry");
    do_por();
    rd(8'h18, v); check("R9 por clears cause", v, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    addr = 8'd0; wr_data = 32'd0;
    wait_cyc(3);
    por_n = 1'b1;
    t_reset();
    t_format_idle();
    t_sticky_kick();
    t_retime_fire();
    t_zero_and_two();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule